// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a real address through a small array of block translation pairs. Each pair has an upper word and a lower word. The upper word holds the effective block index, a length mask, and one enable bit for each of the supervisor and user privilege levels. The lower word holds the real block number and a two-bit protection code. Instruction fetches look only at the instruction set of pairs, and loads and stores look only at the data set. All entries of the selected set are compared in parallel. The lowest-numbered entry that matches and is enabled for the current privilege level decides the outcome, which is either a grant or a protection violation.

The length mask makes a block larger. Each mask bit that is set drops one address bit from the compare and passes that address bit through to the real address. A separate write port loads any word of any pair. A request is a single-cycle strobe. The response follows one clock later as a single-cycle result. A two-state machine sequences it: `ST_IDLE` moves to `ST_RESP` when `req_valid` is high. `ST_RESP` stays in `ST_RESP` when a new strobe arrives and returns to `ST_IDLE` when no strobe arrives.

Top module: `bat_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low and every pair reads as zero, so any lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. When `rsp_valid` is low, `rsp_hit` and `rsp_viol` are low.
- R3: An entry matches when address bits 31:28 equal upper-word bits 31:28, and address bits 27:17 equal upper-word bits 27:17 after the masked positions are forced to zero. The length mask is upper-word bits 12:2, and mask bit 2+i covers address bit 17+i.
- R4: An entry is enabled in supervisor mode (`req_user`=0) when upper bit 1 is set, and in user mode when upper bit 0 is set. A matching entry that is not enabled is treated as no match.
- R5: Lower-word bits 1:0 give the rights. The value 0 gives none, 2 gives read/write/execute, and 1 or 3 give read/execute. `rsp_prot` carries these rights as bit 2 read, bit 1 write, bit 0 execute.
- R6: A fetch needs execute, a store needs write and a load needs read. When the deciding entry grants the needed right, `rsp_hit`=1. When it does not, `rsp_viol`=1. `rsp_hit` and `rsp_viol` are never both high.
- R7: The real address is built from three parts: lower bits 31:28; then (address bits 27:17 AND mask) OR lower bits 27:17; then address bits 16:0 unchanged.
- R8: The lowest-indexed enabled match decides the result, even when it is a violation and a higher entry would grant. `rsp_entry` reports its index.
- R9: Fetches (`req_ifetch`=1) use the instruction set and data accesses use the data set. On writes, `wr_iset`=1 selects the instruction set.
- R10: A write in the same cycle as a request does not affect that request. It does affect the next request.
- R11: On a miss, `rsp_hit`, `rsp_viol`, `rsp_entry`, `rsp_prot` and `rsp_paddr` are all zero.
- R12: `wr_lower`=1 writes the lower word of the pair chosen by `wr_idx`, and `wr_lower`=0 writes the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_store | input | 1 | 1 = store (data accesses only) |
| req_addr | input | 32 | Effective address |
| wr_en | input | 1 | Pair word write strobe |
| wr_iset | input | 1 | 1 = instruction set, 0 = data set |
| wr_idx | input | 2 | Pair index |
| wr_lower | input | 1 | 1 = lower word, 0 = upper word |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Access granted |
| rsp_viol | output | 1 | Protection violation |
| rsp_entry | output | 2 | Deciding entry index |
| rsp_prot | output | 3 | Rights {read, write, execute} |
| rsp_paddr | output | 32 | Real address |

## Verification
Every result of a lookup is due exactly one clock edge after the edge that samples `req_valid`. The result then lasts one cycle. The bench drives inputs on the falling edge and holds the strobe over a single rising edge. It reads all response ports on the following falling edge, and it reads `rsp_valid` once more a cycle later to confirm that the pulse has ended. Pair writes land on the rising edge that samples `wr_en`. For this reason the same-cycle case checks that the old contents answer the concurrent lookup, and that the new contents answer only the next lookup.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int WORD_W     = 32;
    localparam int HI_MSB     = 31;
    localparam int HI_LSB     = 28;
    localparam int MID_MSB    = 27;
    localparam int MID_LSB    = 17;
    localparam int MID_W      = MID_MSB - MID_LSB + 1;
    localparam int LEN_LSB    = 2;
    localparam int LEN_MSB    = LEN_LSB + MID_W - 1;
    localparam int SUP_EN_BIT = 1;
    localparam int USR_EN_BIT = 0;
    localparam int PP_W       = 2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xlt_state_e;

    function automatic rights_t decode_pp(input logic [PP_W-1:0] pp);
        rights_t r;
        unique case (pp)
            2'd0:    r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
            2'd2:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            default: r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_ENTRY = 4,
    parameter int IDX_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_iset,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_lower,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [NUM_ENTRY-1:0][WORD_W-1:0]  ins_up,
    output logic [NUM_ENTRY-1:0][WORD_W-1:0]  ins_lo,
    output logic [NUM_ENTRY-1:0][WORD_W-1:0]  dat_up,
    output logic [NUM_ENTRY-1:0][WORD_W-1:0]  dat_lo
);

    for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_pair
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ins_up[e] <= '0;
                ins_lo[e] <= '0;
                dat_up[e] <= '0;
                dat_lo[e] <= '0;
            end else if (sel) begin
                unique case ({wr_iset, wr_lower})
                    2'b10:   ins_up[e] <= wr_data;
                    2'b11:   ins_lo[e] <= wr_data;
                    2'b00:   dat_up[e] <= wr_data;
                    default: dat_lo[e] <= wr_data;
                endcase
            end
        end
    end

endmodule

// File: rtl/bat_match_cell.sv
module bat_match_cell
    import bat_pkg::*;
(
    input  logic [WORD_W-1:0] up_word,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] addr,
    input  logic              user_mode,
    output logic              sel_ok,
    output rights_t           rights,
    output logic [WORD_W-1:0] paddr
);

    logic [MID_W-1:0] len_mask;
    logic             hi_eq;
    logic             mid_eq;
    logic             enabled;

    always_comb begin
        len_mask = up_word[LEN_MSB:LEN_LSB];
        hi_eq    = (addr[HI_MSB:HI_LSB] == up_word[HI_MSB:HI_LSB]);
        mid_eq   = ((addr[MID_MSB:MID_LSB] & ~len_mask) == up_word[MID_MSB:MID_LSB]);
        enabled  = user_mode ? up_word[USR_EN_BIT] : up_word[SUP_EN_BIT];
        sel_ok   = hi_eq && mid_eq && enabled;
        rights   = decode_pp(lo_word[PP_W-1:0]);
        paddr    = {lo_word[HI_MSB:HI_LSB],
                    (addr[MID_MSB:MID_LSB] & len_mask) | lo_word[MID_MSB:MID_LSB],
                    addr[MID_LSB-1:0]};
    end

endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick #(
    parameter int NUM_ENTRY = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_ENTRY-1:0] cand,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENTRY - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENTRY = 4,
    localparam int IDX_W    = (NUM_ENTRY > 1) ? $clog2(NUM_ENTRY) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ifetch,
    input  logic              req_user,
    input  logic              req_store,
    input  logic [31:0]       req_addr,
    input  logic              wr_en,
    input  logic              wr_iset,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_lower,
    input  logic [31:0]       wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_viol,
    output logic [IDX_W-1:0]  rsp_entry,
    output logic [2:0]        rsp_prot,
    output logic [31:0]       rsp_paddr
);

    logic [NUM_ENTRY-1:0][WORD_W-1:0] ins_up, ins_lo, dat_up, dat_lo;
    logic [NUM_ENTRY-1:0][WORD_W-1:0] cur_up, cur_lo;
    logic [NUM_ENTRY-1:0]             cand;
    rights_t                          cell_rights [NUM_ENTRY];
    logic [WORD_W-1:0]                cell_paddr  [NUM_ENTRY];

    bat_regfile #(.NUM_ENTRY(NUM_ENTRY), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_iset  (wr_iset),
        .wr_idx   (wr_idx),
        .wr_lower (wr_lower),
        .wr_data  (wr_data),
        .ins_up   (ins_up),
        .ins_lo   (ins_lo),
        .dat_up   (dat_up),
        .dat_lo   (dat_lo)
    );

    assign cur_up = req_ifetch ? ins_up : dat_up;
    assign cur_lo = req_ifetch ? ins_lo : dat_lo;

    for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_cell
        bat_match_cell u_cell (
            .up_word   (cur_up[e]),
            .lo_word   (cur_lo[e]),
            .addr      (req_addr),
            .user_mode (req_user),
            .sel_ok    (cand[e]),
            .rights    (cell_rights[e]),
            .paddr     (cell_paddr[e])
        );
    end

    logic             found;
    logic [IDX_W-1:0] win_idx;

    bat_prio_pick #(.NUM_ENTRY(NUM_ENTRY), .IDX_W(IDX_W)) u_pick (
        .cand  (cand),
        .found (found),
        .idx   (win_idx)
    );

    rights_t     win_rights;
    logic [31:0] win_paddr;
    logic        need_ok;

    always_comb begin
        win_rights = cell_rights[win_idx];
        win_paddr  = cell_paddr[win_idx];
        if (req_ifetch)      need_ok = win_rights.ex;
        else if (req_store)  need_ok = win_rights.wr;
        else                 need_ok = win_rights.rd;
    end

    xlt_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = req_valid ? ST_RESP : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_entry <= '0;
            rsp_prot  <= '0;
            rsp_paddr <= '0;
        end else if (req_valid && found) begin
            rsp_hit   <= need_ok;
            rsp_viol  <= !need_ok;
            rsp_entry <= win_idx;
            rsp_prot  <= win_rights;
            rsp_paddr <= win_paddr;
        end else begin
            rsp_hit   <= 1'b0;
            rsp_viol  <= 1'b0;
            rsp_entry <= '0;
            rsp_prot  <= '0;
            rsp_paddr <= '0;
        end
    end

    assign rsp_valid = (state == ST_RESP);

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ifetch,
    input logic             req_store,
    input logic [31:0]      req_addr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_viol,
    input logic [IDX_W-1:0] rsp_entry,
    input logic [2:0]       rsp_prot,
    input logic [31:0]      rsp_paddr
);

    p_req_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_viol));

    p_hit_viol_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_viol));

    p_no_rights_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_prot == 3'b000) |-> !rsp_hit);

    p_store_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(req_store) && !$past(req_ifetch)) |-> rsp_prot[1]);

    p_fetch_needs_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(req_ifetch)) |-> rsp_prot[0]);

    p_offset_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_viol) |-> (rsp_paddr[16:0] == $past(req_addr[16:0])));

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_viol) |->
            (rsp_paddr == 32'd0 && rsp_prot == 3'd0 && rsp_entry == '0));

endmodule

bind bat_xlate bat_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ifetch (req_ifetch),
    .req_store  (req_store),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_viol   (rsp_viol),
    .rsp_entry  (rsp_entry),
    .rsp_prot   (rsp_prot),
    .rsp_paddr  (rsp_paddr)
);

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ifetch = 1'b0, req_user = 1'b0, req_store = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wr_en = 1'b0, wr_iset = 1'b0, wr_lower = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid, rsp_hit, rsp_viol;
    logic [1:0]  rsp_entry;
    logic [2:0]  rsp_prot;
    logic [31:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bat_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ifetch(req_ifetch), .req_user(req_user),
        .req_store(req_store), .req_addr(req_addr),
        .wr_en(wr_en), .wr_iset(wr_iset), .wr_idx(wr_idx), .wr_lower(wr_lower),
        .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
        .rsp_entry(rsp_entry), .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic iset, input logic [1:0] idx, input logic lower,
                           input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_iset = iset; wr_idx = idx; wr_lower = lower; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobe for one rising edge; outputs are read on the falling edge after it.
    task automatic lookup(input logic f, input logic u, input logic s, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_ifetch = f; req_user = u; req_store = s; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic h, input logic v,
                              input logic [1:0] e, input logic [2:0] p, input logic [31:0] pa);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " hit"},   32'(rsp_hit),   32'(h));
        check({tag, " viol"},  32'(rsp_viol),  32'(v));
        check({tag, " entry"}, 32'(rsp_entry), 32'(e));
        check({tag, " prot"},  32'(rsp_prot),  32'(p));
        check({tag, " paddr"}, rsp_paddr,      pa);
    endtask

    // {fetch, user, store, addr, hit, viol, entry, prot, paddr}
    localparam int NV = 15;
    localparam logic [73:0] VEC [NV] = '{
        {3'b000, 32'h1000_4567, 1'b1, 1'b0, 2'd0, 3'b111, 32'h8000_4567}, // R3 mask 0
        {3'b001, 32'h1001_FFFC, 1'b1, 1'b0, 2'd0, 3'b111, 32'h8001_FFFC}, // R6 store
        {3'b000, 32'h1002_0000, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}, // R3 R11 outside
        {3'b010, 32'h1000_4567, 1'b1, 1'b0, 2'd2, 3'b111, 32'h9010_4567}, // R4 user entry
        {3'b011, 32'h1006_5432, 1'b1, 1'b0, 2'd2, 3'b111, 32'h9016_5432}, // R7 mask pass
        {3'b010, 32'h1008_0000, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}, // R3 unmasked bit
        {3'b000, 32'h2ABC_DEF0, 1'b1, 1'b0, 2'd1, 3'b101, 32'h4ABC_DEF0}, // R5 RX
        {3'b001, 32'h2000_1234, 1'b0, 1'b1, 2'd1, 3'b101, 32'h4000_1234}, // R8 first decides
        {3'b010, 32'h2FFF_FFFF, 1'b1, 1'b0, 2'd1, 3'b101, 32'h4FFF_FFFF}, // R4 both modes
        {3'b100, 32'h3001_0ABC, 1'b1, 1'b0, 2'd0, 3'b101, 32'h5001_0ABC}, // R9 fetch set
        {3'b110, 32'h3001_0ABC, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}, // R4 sup only
        {3'b110, 32'h0000_4000, 1'b0, 1'b1, 2'd1, 3'b000, 32'h6000_4000}, // R5 none
        {3'b000, 32'h3001_0ABC, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}, // R9 data set
        {3'b100, 32'h1000_4567, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}, // R9 inst set
        {3'b100, 32'h2ABC_DEF0, 1'b0, 1'b0, 2'd0, 3'b000, 32'h0000_0000}  // R11 miss
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        lookup(1'b0, 1'b0, 1'b0, 32'h0000_0000);
        expect_rsp("R1 cleared pairs miss", 1'b0, 1'b0, 2'd0, 3'b000, 32'h0);
        @(negedge clk);
        check("R2 pulse ends", 32'(rsp_valid), 32'd0);

        // Data set (R12 upper/lower selection)
        wr_word(1'b0, 2'd0, 1'b0, 32'h1000_0002);
        wr_word(1'b0, 2'd0, 1'b1, 32'h8000_0002);
        wr_word(1'b0, 2'd1, 1'b0, 32'h2000_1FFF);
        wr_word(1'b0, 2'd1, 1'b1, 32'h4000_0001);
        wr_word(1'b0, 2'd2, 1'b0, 32'h1000_000D);
        wr_word(1'b0, 2'd2, 1'b1, 32'h9010_0002);
        wr_word(1'b0, 2'd3, 1'b0, 32'h2000_0003);
        wr_word(1'b0, 2'd3, 1'b1, 32'hC000_0002);
        // Instruction set (R9)
        wr_word(1'b1, 2'd0, 1'b0, 32'h3000_0002);
        wr_word(1'b1, 2'd0, 1'b1, 32'h5000_0001);
        wr_word(1'b1, 2'd1, 1'b0, 32'h0000_0001);
        wr_word(1'b1, 2'd1, 1'b1, 32'h6000_0000);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            lookup(v[73], v[72], v[71], v[70:39]);
            expect_rsp($sformatf("R3 R4 R5 R6 R7 R8 R9 vec %0d", i),
                       v[38], v[37], v[36:35], v[34:32], v[31:0]);
        end

        // R2 back-to-back strobes
        @(negedge clk);
        req_valid = 1'b1; req_ifetch = 1'b0; req_user = 1'b0; req_store = 1'b0;
        req_addr = 32'h1000_0010;
        @(negedge clk);
        req_addr = 32'h2000_0020;
        expect_rsp("R2 first of pair", 1'b1, 1'b0, 2'd0, 3'b111, 32'h8000_0010);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R2 second of pair", 1'b1, 1'b0, 2'd1, 3'b101, 32'h4000_0020);
        @(negedge clk);
        check("R2 idle after pair", 32'(rsp_valid), 32'd0);
        check("R2 hit low when idle", 32'(rsp_hit), 32'd0);

        // R10 write concurrent with lookup
        @(negedge clk);
        req_valid = 1'b1; req_ifetch = 1'b0; req_user = 1'b0; req_store = 1'b0;
        req_addr = 32'h3001_0ABC;
        wr_en = 1'b1; wr_iset = 1'b0; wr_idx = 2'd3; wr_lower = 1'b0; wr_data = 32'h3000_0002;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        expect_rsp("R10 old contents answer", 1'b0, 1'b0, 2'd0, 3'b000, 32'h0);
        lookup(1'b0, 1'b0, 1'b0, 32'h3001_0ABC);
        expect_rsp("R10 new contents answer", 1'b1, 1'b0, 2'd3, 3'b111, 32'hC001_0ABC);

        // R12 lower word rewrite only changes rights and real block
        wr_word(1'b0, 2'd3, 1'b1, 32'hE000_0001);
        lookup(1'b0, 1'b0, 1'b0, 32'h3001_0ABC);
        expect_rsp("R12 lower rewrite load", 1'b1, 1'b0, 2'd3, 3'b101, 32'hE001_0ABC);
        lookup(1'b0, 1'b0, 1'b1, 32'h3001_0ABC);
        expect_rsp("R6 store on RX", 1'b0, 1'b1, 2'd3, 3'b101, 32'hE001_0ABC);
        lookup(1'b1, 1'b0, 1'b0, 32'h3001_0ABC);
        expect_rsp("R9 fetch unaffected", 1'b1, 1'b0, 2'd0, 3'b101, 32'h5001_0ABC);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule